// File: doc/BRIEF.md
# Fault Latch and Retry Controller

This block keeps a small register of sticky fault flags for a hot-swap style power path and decides, every clock, whether the external power switch may be on. Four live fault indications enter as synchronous digital levels: undervoltage, overvoltage, overcurrent and power-not-good. Each live level sets its own sticky flag. A fifth sticky flag records that the enable request fell. The flags are cleared only by specific events, and each event clears a specific set of flags. A flag whose live fault is still present cannot be cleared by any event.

The switch decision has two modes, selected by a control bit. With retry off, a latched undervoltage, overvoltage or overcurrent flag keeps the switch off until the flag is cleared. With retry on, the latched flags are not used for gating. Only the live levels hold the switch off. After each overcurrent, a cool-down window of a parameterised number of cycles follows before the next restart attempt. Retrying never clears any flag.

A plain read/write port gives access to a control register, a read-only view of the live levels, and the flag register. Reads return data one cycle after the address is presented.

Top module: `fault_guard`

## Requirements
- R1: Live fault input bits map to flag bits 0 (undervoltage), 1 (overvoltage), 2 (overcurrent) and 3 (power-not-good). A live bit that is high at a clock edge sets its flag. The flag stays set after the live bit drops.
- R2: Writing control bit 1 (hold bit) from 1 to 0 clears flags 0 to 3. Flag 4 is left unchanged.
- R3: When `rstpin_uv` is sampled high for QUAL_CYC consecutive cycles, all five flags clear at the last of those edges. A shorter high pulse has no effect.
- R4: A high `lockout` clears all five flags and forces `sw_on` low on the next edge.
- R5: A falling edge of `en_req` clears flags 0 to 3 and sets flag 4. Any set takes priority over a clear in the same cycle.
- R6: A flag whose live bit is high at the edge stays set, whatever clear event happens in that cycle, including a bus write.
- R7: A write to address 2 clears each flag whose write-data bit is 0. A write-data bit of 1 leaves its flag unchanged.
- R8: With control bit 0 (retry) at 0, `sw_on` is registered as `en_req` AND NOT `lockout` AND NOT any of flags or live bits 0 to 2. The switch turns back on as soon as those flags are cleared.
- R9: With retry at 1, flags are ignored for gating. `sw_on` is held low only while live bits 0 to 2, `lockout` or the cool-down window are active, or while `en_req` is low.
- R10: Every edge with live overcurrent high loads a cool-down of COOL_CYC cycles. In retry mode `sw_on` stays low throughout this window. The flag register is never cleared by retrying.
- R11: `bus_rdata` is registered from the address of the previous cycle. Address 0 returns the control bits [1:0], address 1 returns the live bits [3:0], address 2 returns the flags [4:0], and address 3 returns zero.
- R12: Synchronous reset clears the flags, the control bits, the cool-down, `sw_on` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Switch enable request |
| lockout | input | 1 | Internal supply undervoltage lockout |
| rstpin_uv | input | 1 | Undervoltage level on the reset pin, qualified by duration |
| live_flt | input | 4 | Live faults: [0] UV, [1] OV, [2] OC, [3] power-not-good |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | 5 | Registered read data |
| sw_on | output | 1 | Registered switch enable |

## Verification
The hardest state to reach is retry mode during an active cool-down, with a latched flag still set. In that state the latched flag must not gate the switch, while the cool-down must. The stimulus first latches an overvoltage flag and switches retry on. It then shows the switch running with the flag still set, and only then applies a one-cycle overcurrent. The switch is observed low for the whole window and back on at the cycle the window ends. Clears under a persisting live fault are reached by holding the live input high across a zero write. Short and long reset-pin pulses straddle the qualification length.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int NLIVE = 4;
  localparam int NFLT = NLIVE + 1;
  localparam int BIT_EN_CHG = NLIVE;
  localparam int CTRL_RETRY = 0;
  localparam int CTRL_HOLD = 1;
  localparam logic [NFLT-1:0] CLR_LIVE_ONLY = {1'b0, {NLIVE{1'b1}}};
  localparam logic [NFLT-1:0] CLR_EVERY = {NFLT{1'b1}};
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_LIVE  = 2'd1,
    ADDR_FAULT = 2'd2,
    ADDR_NONE  = 2'd3
  } addr_e;
endpackage

// File: rtl/fg_filter.sv
module fg_filter #(
  parameter int QUAL_CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic hit
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);
  localparam logic [CW-1:0] SAT = CW'(QUAL_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (!level)
      cnt <= '0;
    else if (cnt != SAT)
      cnt <= cnt + 1'b1;
  end

  assign hit = level && (cnt == LAST);

  // one qualified event per continuous assertion
  assert_single_hit_R3: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/fg_fault_reg.sv
module fg_fault_reg
  import fg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NLIVE-1:0] live,
  input  logic            hold_fall,
  input  logic            pin_hit,
  input  logic            lockout,
  input  logic            en_fall,
  input  logic            wr_fault,
  input  logic [NFLT-1:0] wdata,
  output logic [NFLT-1:0] fault_q
);
  logic [NFLT-1:0] clr_mask;
  logic [NFLT-1:0] set_mask;

  always_comb begin
    clr_mask = '0;
    if (hold_fall) clr_mask = clr_mask | CLR_LIVE_ONLY;
    if (en_fall)   clr_mask = clr_mask | CLR_LIVE_ONLY;
    if (pin_hit)   clr_mask = clr_mask | CLR_EVERY;
    if (lockout)   clr_mask = clr_mask | CLR_EVERY;
    if (wr_fault)  clr_mask = clr_mask | ~wdata;
  end

  assign set_mask = {en_fall, live};

  for (genvar i = 0; i < NFLT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        fault_q[i] <= 1'b0;
      else if (set_mask[i])
        fault_q[i] <= 1'b1;
      else if (clr_mask[i])
        fault_q[i] <= 1'b0;
    end
  end

  assert_live_persists_R6: assert property (@(posedge clk) disable iff (rst)
    (|live) |=> ((fault_q[NLIVE-1:0] & $past(live)) == $past(live)));

  assert_en_change_R5: assert property (@(posedge clk) disable iff (rst)
    en_fall |=> fault_q[BIT_EN_CHG]);

  assert_full_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (pin_hit && !en_fall && live == '0) |=> fault_q == '0);

  assert_hold_keeps_chg_R2: assert property (@(posedge clk) disable iff (rst)
    (hold_fall && !pin_hit && !lockout && !wr_fault && fault_q[BIT_EN_CHG])
      |=> fault_q[BIT_EN_CHG]);
endmodule

// File: rtl/fg_gate.sv
module fg_gate #(
  parameter int COOL_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_req,
  input  logic       lockout,
  input  logic       retry,
  input  logic [2:0] live,
  input  logic [2:0] fault_lat,
  output logic       sw_on
);
  localparam int KW = $clog2(COOL_CYC + 1);
  localparam logic [KW-1:0] COOL_LOAD = KW'(COOL_CYC);

  logic [KW-1:0] cool;
  logic          cooling;
  logic          block;

  assign cooling = (cool != '0);

  always_ff @(posedge clk) begin
    if (rst)
      cool <= '0;
    else if (live[2])
      cool <= COOL_LOAD;
    else if (cooling)
      cool <= cool - 1'b1;
  end

  always_comb begin
    if (retry)
      block = (|live) || cooling;
    else
      block = |(fault_lat | live);
  end

  always_ff @(posedge clk) begin
    if (rst)
      sw_on <= 1'b0;
    else
      sw_on <= en_req && !lockout && !block;
  end

  assert_latched_block_R8: assert property (@(posedge clk) disable iff (rst)
    (!retry && (|fault_lat)) |=> !sw_on);

  assert_live_block_R9: assert property (@(posedge clk) disable iff (rst)
    (retry && (|live)) |=> !sw_on);

  assert_cool_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (retry && cooling) |=> !sw_on);

  assert_lockout_off_R4: assert property (@(posedge clk) disable iff (rst)
    lockout |=> !sw_on);
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fg_pkg::*;
#(
  parameter int QUAL_CYC = 500,
  parameter int COOL_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_req,
  input  logic             lockout,
  input  logic             rstpin_uv,
  input  logic [NLIVE-1:0] live_flt,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [NFLT-1:0]  bus_wdata,
  output logic [NFLT-1:0]  bus_rdata,
  output logic             sw_on
);
  logic [1:0]      ctrl_q;
  logic            en_q;
  logic            en_fall;
  logic            hold_fall;
  logic            wr_ctrl;
  logic            wr_fault;
  logic            pin_hit;
  logic [NFLT-1:0] fault_q;

  assign wr_ctrl   = bus_we && (bus_addr == ADDR_CTRL);
  assign wr_fault  = bus_we && (bus_addr == ADDR_FAULT);
  assign hold_fall = wr_ctrl && ctrl_q[CTRL_HOLD] && !bus_wdata[CTRL_HOLD];
  assign en_fall   = en_q && !en_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= en_req;
      if (wr_ctrl)
        ctrl_q <= bus_wdata[1:0];
    end
  end

  fg_filter #(.QUAL_CYC(QUAL_CYC)) u_filter (
    .clk   (clk),
    .rst   (rst),
    .level (rstpin_uv),
    .hit   (pin_hit)
  );

  fg_fault_reg u_flags (
    .clk       (clk),
    .rst       (rst),
    .live      (live_flt),
    .hold_fall (hold_fall),
    .pin_hit   (pin_hit),
    .lockout   (lockout),
    .en_fall   (en_fall),
    .wr_fault  (wr_fault),
    .wdata     (bus_wdata),
    .fault_q   (fault_q)
  );

  fg_gate #(.COOL_CYC(COOL_CYC)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .en_req    (en_req),
    .lockout   (lockout),
    .retry     (ctrl_q[CTRL_RETRY]),
    .live      (live_flt[2:0]),
    .fault_lat (fault_q[2:0]),
    .sw_on     (sw_on)
  );

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else begin
      unique case (bus_addr)
        ADDR_CTRL:  bus_rdata <= {{(NFLT-2){1'b0}}, ctrl_q};
        ADDR_LIVE:  bus_rdata <= {1'b0, live_flt};
        ADDR_FAULT: bus_rdata <= fault_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_NONE) |=> bus_rdata == '0);

  assert_reset_clear_R12: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && !sw_on));
endmodule

// File: tb/fault_guard_bench.sv
module fault_guard_bench;
  localparam int QUAL = 5;
  localparam int COOL = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_req = 1'b0;
  logic       lockout = 1'b0;
  logic       rstpin_uv = 1'b0;
  logic [3:0] live_flt = '0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd2;
  logic [4:0] bus_wdata = '0;
  logic [4:0] bus_rdata;
  logic       sw_on;

  int checks = 0;
  int fails = 0;
  string tag = "R12";
  bit done = 1'b0;

  always #2 clk = ~clk;

  fault_guard #(.QUAL_CYC(QUAL), .COOL_CYC(COOL)) u_fault_guard (
    .clk(clk), .rst(rst), .en_req(en_req), .lockout(lockout),
    .rstpin_uv(rstpin_uv), .live_flt(live_flt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sw_on(sw_on)
  );

  // behavioural reference, updated at each rising edge
  int m_flags, m_ctrl, m_enq, m_pin, m_cool, m_sw, m_rd;

  always @(posedge clk) begin
    int clr, nf, blk, rd;
    bit efall, hfall, hit;
    if (rst) begin
      m_flags = 0; m_ctrl = 0; m_enq = 0; m_pin = 0;
      m_cool = 0; m_sw = 0; m_rd = 0;
    end else begin
      case (bus_addr)
        2'd0: rd = m_ctrl;
        2'd1: rd = live_flt;
        2'd2: rd = m_flags;
        default: rd = 0;
      endcase
      efall = (m_enq == 1) && !en_req;
      hfall = bus_we && bus_addr == 2'd0 && m_ctrl[1] && !bus_wdata[1];
      hit = rstpin_uv && (m_pin == QUAL - 1);
      clr = 0;
      if (hfall || efall) clr = clr | 'h0F;
      if (hit || lockout) clr = clr | 'h1F;
      if (bus_we && bus_addr == 2'd2) clr = clr | (~int'(bus_wdata) & 'h1F);
      nf = (m_flags & ~clr) | int'(live_flt) | (efall ? 'h10 : 0);
      if (m_ctrl[0]) blk = ((live_flt & 7) != 0) || (m_cool != 0);
      else blk = (((m_flags | live_flt) & 7) != 0);
      m_sw = en_req && !lockout && !blk;
      m_cool = live_flt[2] ? COOL : (m_cool > 0 ? m_cool - 1 : 0);
      m_pin = !rstpin_uv ? 0 : (m_pin < QUAL ? m_pin + 1 : m_pin);
      if (bus_we && bus_addr == 2'd0) m_ctrl = bus_wdata[1:0];
      m_enq = en_req;
      m_flags = nf;
      m_rd = rd;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (sw_on !== m_sw[0]) begin
        fails++;
        $display("FAIL %s sw_on actual=%0d expected=%0d at %0t", tag, sw_on, m_sw, $time);
      end
      checks++;
      if (bus_rdata !== m_rd[4:0]) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h at %0t", tag, bus_rdata, m_rd, $time);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [4:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic expect_rd(logic [1:0] a, logic [4:0] exp, string t);
    @(negedge clk); bus_addr = a;
    @(negedge clk);
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s directed read actual=%h expected=%h", t, bus_rdata, exp);
    end
    bus_addr = 2'd2;
  endtask

  task automatic expect_sw(logic exp, string t);
    checks++;
    if (sw_on !== exp) begin
      fails++;
      $display("FAIL %s directed sw_on actual=%0d expected=%0d", t, sw_on, exp);
    end
  endtask

  task automatic live_pulse(logic [3:0] v);
    @(negedge clk); live_flt = v;
    @(negedge clk); live_flt = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    tick(3);
    expect_sw(1'b0, "R12");
    checks++;
    if (bus_rdata !== 5'h00) begin
      fails++;
      $display("FAIL R12 reset rdata actual=%h expected=00", bus_rdata);
    end
    rst = 1'b0;
    tag = "R8";
    en_req = 1'b1;
    tick(3);
    expect_sw(1'b1, "R8");
    tag = "R1";
    live_pulse(4'b0010);
    tick(2);
    expect_rd(2'd2, 5'h02, "R1");
    expect_sw(1'b0, "R8");
    tag = "R7";
    wr(2'd2, 5'h1F);
    expect_rd(2'd2, 5'h02, "R7");
    wr(2'd2, 5'h1D);
    expect_rd(2'd2, 5'h00, "R7");
    tick(1);
    expect_sw(1'b1, "R8");
    tag = "R6";
    @(negedge clk); live_flt = 4'b0100;
    wr(2'd2, 5'h00);
    expect_rd(2'd2, 5'h04, "R6");
    live_flt = '0;
    wr(2'd2, 5'h00);
    expect_rd(2'd2, 5'h00, "R6");
    tag = "R2";
    live_pulse(4'b1001);
    wr(2'd0, 5'h02);
    expect_rd(2'd2, 5'h09, "R2");
    wr(2'd0, 5'h00);
    expect_rd(2'd2, 5'h00, "R2");
    tag = "R5";
    @(negedge clk); en_req = 1'b0;
    tick(2);
    expect_rd(2'd2, 5'h10, "R5");
    en_req = 1'b1;
    wr(2'd0, 5'h02);
    wr(2'd0, 5'h00);
    expect_rd(2'd2, 5'h10, "R2");
    tag = "R3";
    live_pulse(4'b0010);
    @(negedge clk); rstpin_uv = 1'b1;
    tick(QUAL - 2);
    rstpin_uv = 1'b0;
    tick(2);
    expect_rd(2'd2, 5'h12, "R3");
    rstpin_uv = 1'b1;
    tick(QUAL + 1);
    rstpin_uv = 1'b0;
    expect_rd(2'd2, 5'h00, "R3");
    tag = "R4";
    live_pulse(4'b0010);
    @(negedge clk); lockout = 1'b1;
    @(negedge clk); lockout = 1'b0;
    expect_sw(1'b0, "R4");
    expect_rd(2'd2, 5'h00, "R4");
    tick(2);
    tag = "R9";
    wr(2'd0, 5'h01);
    live_pulse(4'b0010);
    tick(2);
    expect_sw(1'b1, "R9");
    expect_rd(2'd2, 5'h02, "R9");
    tag = "R10";
    live_pulse(4'b0100);
    tick(6);
    expect_sw(1'b0, "R10");
    tick(COOL);
    expect_sw(1'b1, "R10");
    expect_rd(2'd2, 5'h06, "R10");
    tag = "R11";
    @(negedge clk); live_flt = 4'b1000;
    expect_rd(2'd1, 5'h08, "R11");
    live_flt = '0;
    expect_rd(2'd3, 5'h00, "R11");
    expect_rd(2'd0, 5'h01, "R11");
    tick(3);
    finish_run();
  end
endmodule